// File: doc/BRIEF.md
# Sync-Triggered Ramp Delay Countdown

This block times the delay before a comparator ramp generator starts to slope. Software writes a delay value into a holding (shadow) register at any time. Each rising edge of an external PWM synchronisation input copies that held value into the working counter. The working counter then steps down by one every clock until it reaches zero, and it stays at zero until the next synchronisation edge.

The current count is visible at an output. A done flag is high whenever the count is zero, so downstream ramp logic can begin its slope when the flag goes high. The synchronisation input is sampled by a register and an edge is detected by comparing it with its previous sample. A level that stays high therefore reloads the counter only once. A shadow write never disturbs a countdown that is already running; it takes effect at the next edge.

Top module: `ramp_delay_counter`

## Requirements
- R1: After reset the count output is 0 and done is 1; the sampled sync history is cleared to low.
- R2: When shadow_we is high at a clock edge, the 16-bit shadow_wdata is stored as the shadow value and becomes visible only through a later load.
- R3: At a clock edge where sync_in is high and its sample from the previous edge was low, count takes the shadow value, even if a countdown is still running.
- R4: At any other clock edge with a nonzero count, count decreases by exactly one.
- R5: With a count of zero and no sync edge, count stays at zero.
- R6: done is high in exactly those cycles in which count is zero.
- R7: sync_in held high over many edges causes only one reload.
- R8: A shadow write during a countdown leaves the running countdown unchanged.
- R9: With a shadow value of 0, count is 0 and done is high in the cycle after the sync edge.
- R10: A shadow value of 0xFFFF loads as 0xFFFF and reaches zero after 65535 further clock edges.
- R11: When a shadow write and a sync edge fall on the same clock edge, the count takes the shadow value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shadow_we | input | 1 | Shadow register write strobe |
| shadow_wdata | input | 16 | Delay value to store |
| sync_in | input | 1 | PWM synchronisation input, rising edge reloads |
| count | output | 16 | Current delay count |
| done | output | 1 | High while count is zero |

## Verification
A corrupted count shows at the count port on the very next clock edge, because every cycle either loads, decrements or holds, and each step has a single legal result. A lost or stale sync history shows as a missed reload, or as a second reload while sync stays high, one cycle after the edge. A shadow register that latches too early or too late shows at the next load as a wrong starting value. These faults are seen most clearly when the write and the sync edge fall on the same cycle. Done is compared with count every cycle, so a decode error shows at once.

// File: rtl/ramp_delay_counter.sv
module ramp_delay_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shadow_we,
  input  logic [W-1:0] shadow_wdata,
  input  logic         sync_in,
  output logic [W-1:0] count,
  output logic         done
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] shadow_q;
  logic [W-1:0] cnt_q;
  logic         sync_q;
  logic         sync_rise;

  assign sync_rise = sync_in & ~sync_q;
  assign count     = cnt_q;
  assign done      = (cnt_q == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= ZERO;
      sync_q   <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (shadow_we) shadow_q <= shadow_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= ZERO;
    else if (sync_rise)      cnt_q <= shadow_q;
    else if (cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
  end

  // R3 R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_q) |=> (count == $past(shadow_q)));

  // R4 R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sync_in && !sync_q) && count != ZERO) |=> (count == $past(count) - ONE));

  // R5 R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sync_in && !sync_q) && done) |=> (count == ZERO && done));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(count) == ONE || $past(sync_in && !sync_q)));

  // R7
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && count != ZERO) |=> (count == $past(count) - ONE));
endmodule

// File: tb/ramp_delay_counter_bench.sv
module ramp_delay_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shadow_we = 1'b0;
  logic [15:0] shadow_wdata = '0;
  logic        sync_in = 1'b0;
  logic [15:0] count;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] m_shadow = '0;
  logic [15:0] m_cnt = '0;
  logic        m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_delay_counter u_ramp_delay_counter (
    .clk(clk), .rst_n(rst_n), .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
    .sync_in(sync_in), .count(count), .done(done)
  );

  task automatic check(input string tag, input logic [15:0] exp_c, input logic exp_d);
    checks++;
    if (count !== exp_c || done !== exp_d) begin
      errors++;
      $display("FAIL %s count=%0h done=%0b expected count=%0h done=%0b", tag, count, done, exp_c, exp_d);
    end
  endtask

  // one clock: drive at negedge, model edge, check after posedge
  task automatic step(input logic we, input logic [15:0] wd, input logic sy, input string tag);
    @(negedge clk);
    shadow_we = we; shadow_wdata = wd; sync_in = sy;
    @(posedge clk);
    if (sy && !m_prev)      m_cnt = m_shadow;
    else if (m_cnt != 0)    m_cnt = m_cnt - 16'd1;
    if (we) m_shadow = wd;
    m_prev = sy;
    #1;
    check(tag, m_cnt, m_cnt == 16'd0);
  endtask

  task automatic t_reset;
    #1 check("R1 reset", 16'd0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", 16'd0, 1'b1);
  endtask

  task automatic t_basic;
    step(1'b1, 16'd5, 1'b0, "R2 write");
    step(1'b0, 16'd0, 1'b1, "R3 load");
    if (count !== 16'd5) begin checks++; errors++; $display("FAIL R3 count=%0d expected 5", count); end
    for (int i = 0; i < 5; i++) step(1'b0, 16'd0, 1'b1, "R4 R6 R7 countdown held high");
    for (int i = 0; i < 4; i++) step(1'b0, 16'd0, 1'b1, "R5 R7 hold zero");
    step(1'b0, 16'd0, 1'b0, "R5 sync low");
  endtask

  task automatic t_write_during;
    step(1'b1, 16'd10, 1'b0, "R2 write 10");
    step(1'b0, 16'd0, 1'b1, "R3 load 10");
    step(1'b0, 16'd0, 1'b0, "R4");
    step(1'b1, 16'd99, 1'b0, "R8 write mid count");
    for (int i = 0; i < 3; i++) step(1'b0, 16'd0, 1'b0, "R8 countdown unchanged");
    step(1'b0, 16'd0, 1'b1, "R3 retrigger loads 99");
    step(1'b0, 16'd0, 1'b0, "R4 after retrigger");
  endtask

  task automatic t_zero;
    step(1'b1, 16'd0, 1'b0, "R2 write 0");
    step(1'b0, 16'd0, 1'b1, "R9 load zero");
    if (done !== 1'b1) begin checks++; errors++; $display("FAIL R9 done=%0b expected 1", done); end
    step(1'b0, 16'd0, 1'b0, "R5");
  endtask

  task automatic t_same_cycle;
    step(1'b1, 16'd7, 1'b0, "R2 write 7");
    step(1'b1, 16'd200, 1'b1, "R11 write and edge together");
    if (count !== 16'd7) begin checks++; errors++; $display("FAIL R11 count=%0d expected 7", count); end
    step(1'b0, 16'd0, 1'b0, "R11 low");
    step(1'b0, 16'd0, 1'b1, "R11 next edge");
    if (count !== 16'd200) begin checks++; errors++; $display("FAIL R11 count=%0d expected 200", count); end
  endtask

  task automatic t_full;
    step(1'b1, 16'hFFFF, 1'b0, "R2 write full");
    step(1'b0, 16'd0, 1'b0, "R10 sync low");
    step(1'b0, 16'd0, 1'b1, "R10 load full");
    if (count !== 16'hFFFF) begin checks++; errors++; $display("FAIL R10 count=%0h expected ffff", count); end
    for (int i = 0; i < 65535; i++) step(1'b0, 16'd0, 1'b0, "R10 full countdown");
    if (done !== 1'b1) begin checks++; errors++; $display("FAIL R10 done=%0b expected 1", done); end
    step(1'b0, 16'd0, 1'b0, "R10 stays zero");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_write_during();
    t_zero();
    t_same_cycle();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule